// File: doc/BRIEF.md
# Sigma-Delta Sample-Phase Resynchronization Controller

This block keeps the conversion instants of one sigma-delta converter node lined up with a synchronization pulse shared across a whole system. A free-running, wrapping timestamp counter marks the cycle in which the global pulse arrives and the cycle in which the converter signals a finished output word. The filter's group delay is given in modulator clock periods. The block scales it to system clock cycles and subtracts it from the data-ready time, which recovers the real sampling instant. The signed difference from the sync time becomes the phase error, reported as a magnitude plus a late/early flag.

An error inside the programmed tolerance leaves the node locked with no action. A larger error is corrected in one of two ways, chosen by a configuration bit. Reset mode pulses a decimation-filter reset and then holds the output marked invalid for a programmed number of output words while the filter settles. Rate mode bends the modulator clock divider by a bounded amount for as many modulator periods as needed to absorb the error, then returns it to nominal. The block itself generates the modulator clock enable, so the output data rate (modulator rate divided by the decimation ratio) follows the divider.

The controller states are IDLE (code 0, after reset, waiting for a sync), MEASURE (1, sync captured, waiting for data-ready), CORRECT (2, divider offset active), SETTLE (3, filter settling after a reset) and LOCKED (4). The transitions are: IDLE to MEASURE on sync; MEASURE to LOCKED on data-ready with the error within tolerance; MEASURE to SETTLE on data-ready with a large error in reset mode; MEASURE to CORRECT on data-ready with a large error in rate mode; CORRECT to LOCKED when the residual error is used up; SETTLE to LOCKED once the settle count has elapsed; LOCKED to MEASURE on sync. A sync seen in MEASURE recaptures the sync time.

Top module: `sd_phase_aligner`

## Requirements
- R1: After reset the state output reads 0 (IDLE), and filt_rst and data_invalid are low.
- R2: Outside CORRECT, mod_clk_en is a one-cycle pulse that repeats every cfg_div_nom system clock cycles.
- R3: On the first drdy accepted in MEASURE, err_mag and err_late take the value of D = (t_drdy - t_sync) - cfg_group_delay * cfg_div_nom, where the t values are the cycles in which the pulses are sampled. err_mag is |D| and err_late is 1 when D >= 0, meaning the sample lies at or after the sync.
- R4: If err_mag <= cfg_tol, the state goes straight from MEASURE to LOCKED, with no filter reset and no divider change.
- R5: In reset mode (cfg_reset_mode=1) with a large error, filt_rst is high for exactly one cycle, the first cycle of SETTLE.
- R6: In rate mode, every modulator period differs from cfg_div_nom by at most cfg_max_step. Periods are shorter when err_late=1 and longer when err_late=0.
- R7: In rate mode, the sum over all periods of (period - cfg_div_nom) equals -err_mag when late and +err_mag when early. The divider then returns to nominal, the state becomes LOCKED, and data_invalid is high throughout CORRECT.
- R8: A sync pulse during CORRECT or SETTLE is ignored: the correction finishes and the state ends in LOCKED, not MEASURE.
- R9: The error arithmetic is modular in the timestamp width, so a measurement that straddles the counter wrap gives the true difference.
- R10: drdy pulses in LOCKED or IDLE leave err_mag, err_late and the state unchanged.
- R11: In SETTLE, data_invalid stays high until cfg_settle drdy pulses have been counted, then the state becomes LOCKED. A zero count returns to LOCKED on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_pulse | input | 1 | Global synchronization pulse, one cycle |
| drdy | input | 1 | Converter data-ready pulse, one cycle |
| cfg_reset_mode | input | 1 | 1 selects filter-reset correction, 0 selects rate correction |
| cfg_group_delay | input | GD_W | Filter group delay in modulator clock periods |
| cfg_div_nom | input | DIV_W | Nominal modulator divider in system cycles |
| cfg_max_step | input | DIV_W | Largest allowed divider offset |
| cfg_tol | input | TS_W | Error tolerance in system cycles |
| cfg_settle | input | CNT_W | Output words marked invalid after a filter reset |
| mod_clk_en | output | 1 | Modulator clock enable pulse |
| filt_rst | output | 1 | Decimation filter reset strobe |
| data_invalid | output | 1 | Current output words are not trustworthy |
| err_late | output | 1 | 1 when the last sample was at or after the sync |
| err_mag | output | TS_W | Magnitude of the last measured phase error |
| state_o | output | 3 | Controller state code |

## Verification
A stuck or wrong controller state is visible in the same cycle on state_o and data_invalid. It also shows within one modulator period in the spacing of mod_clk_en. A residual counter that is off by even one cycle changes the total bend of the divider, and the summed period deviation exposes this as soon as the node relocks. A wrong sign or scaling in the error path appears in err_mag and err_late in the cycle after the data-ready pulse. An error path that loses the wrap shows up only in a measurement that crosses the counter rollover, so one is placed there on purpose.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_MEASURE = 3'd1,
        ST_CORRECT = 3'd2,
        ST_SETTLE  = 3'd3,
        ST_LOCKED  = 3'd4
    } sdp_state_e;
endpackage

// File: rtl/sdp_timestamp.sv
module sdp_timestamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_take,
    output logic [TS_W-1:0] now_ts,
    output logic [TS_W-1:0] sync_ts
);
    // free-running counter, wraps naturally
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_ts  <= '0;
            sync_ts <= '0;
        end else begin
            now_ts <= now_ts + 1'b1;
            if (sync_take) sync_ts <= now_ts;
        end
    end
endmodule

// File: rtl/sdp_phase_meas.sv
module sdp_phase_meas #(
    parameter int TS_W  = 32,
    parameter int GD_W  = 16,
    parameter int DIV_W = 8
) (
    input  logic [TS_W-1:0]  now_ts,
    input  logic [TS_W-1:0]  sync_ts,
    input  logic [GD_W-1:0]  group_delay,
    input  logic [DIV_W-1:0] div_nom,
    output logic [TS_W-1:0]  mag,
    output logic             late
);
    localparam int PROD_W = GD_W + DIV_W;

    logic [PROD_W-1:0] gd_cycles;
    logic [TS_W-1:0]   sample_ts;
    logic [TS_W-1:0]   diff;

    always_comb begin
        gd_cycles = PROD_W'(group_delay) * PROD_W'(div_nom);
        sample_ts = now_ts - TS_W'(gd_cycles);
        diff      = sample_ts - sync_ts;          // modular difference
        late      = ~diff[TS_W-1];                // sign bit limits range to half
        mag       = diff[TS_W-1] ? (~diff + 1'b1) : diff;
    end
endmodule

// File: rtl/sdp_mod_clkgen.sv
module sdp_mod_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_eff,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= div_eff - 1'b1;
        else           cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/sd_phase_aligner.sv
module sd_phase_aligner #(
    parameter int TS_W  = 32,
    parameter int GD_W  = 16,
    parameter int DIV_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_pulse,
    input  logic             drdy,
    input  logic             cfg_reset_mode,
    input  logic [GD_W-1:0]  cfg_group_delay,
    input  logic [DIV_W-1:0] cfg_div_nom,
    input  logic [DIV_W-1:0] cfg_max_step,
    input  logic [TS_W-1:0]  cfg_tol,
    input  logic [CNT_W-1:0] cfg_settle,
    output logic             mod_clk_en,
    output logic             filt_rst,
    output logic             data_invalid,
    output logic             err_late,
    output logic [TS_W-1:0]  err_mag,
    output logic [2:0]       state_o
);
    import sdp_pkg::*;

    sdp_state_e       st, st_nx;
    logic [TS_W-1:0]  now_ts, sync_ts, meas_mag;
    logic             meas_late, sync_take, meas_hit, over_tol;
    logic [TS_W-1:0]  residual;
    logic [CNT_W-1:0] settle_cnt;
    logic [DIV_W-1:0] step_now, div_eff;

    assign sync_take = sync_pulse &&
                       (st == ST_IDLE || st == ST_MEASURE || st == ST_LOCKED);
    assign meas_hit  = drdy && (st == ST_MEASURE);
    assign over_tol  = meas_mag > cfg_tol;

    sdp_timestamp #(.TS_W(TS_W)) u_ts (
        .clk(clk), .rst_n(rst_n), .sync_take(sync_take),
        .now_ts(now_ts), .sync_ts(sync_ts)
    );

    sdp_phase_meas #(.TS_W(TS_W), .GD_W(GD_W), .DIV_W(DIV_W)) u_meas (
        .now_ts(now_ts), .sync_ts(sync_ts),
        .group_delay(cfg_group_delay), .div_nom(cfg_div_nom),
        .mag(meas_mag), .late(meas_late)
    );

    // divider offset: bounded by max step, trimmed on the last period
    always_comb begin
        if (residual < TS_W'(cfg_max_step)) step_now = DIV_W'(residual);
        else                                step_now = cfg_max_step;
        if (st == ST_CORRECT)
            div_eff = err_late ? (cfg_div_nom - step_now) : (cfg_div_nom + step_now);
        else
            div_eff = cfg_div_nom;
    end

    sdp_mod_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .div_eff(div_eff), .tick(mod_clk_en)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:    if (sync_pulse) st_nx = ST_MEASURE;
            ST_MEASURE: if (drdy) begin
                            if (!over_tol)          st_nx = ST_LOCKED;
                            else if (cfg_reset_mode) st_nx = ST_SETTLE;
                            else                    st_nx = ST_CORRECT;
                        end
            ST_CORRECT: if (mod_clk_en && residual == '0) st_nx = ST_LOCKED;
            ST_SETTLE:  if (settle_cnt == '0) st_nx = ST_LOCKED;
            ST_LOCKED:  if (sync_pulse) st_nx = ST_MEASURE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    // measurement, residual and settle bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_mag    <= '0;
            err_late   <= 1'b0;
            residual   <= '0;
            settle_cnt <= '0;
            filt_rst   <= 1'b0;
        end else begin
            filt_rst <= meas_hit && over_tol && cfg_reset_mode;
            if (meas_hit) begin
                err_mag    <= meas_mag;
                err_late   <= meas_late;
                residual   <= meas_mag;
                settle_cnt <= cfg_settle;
            end else if (st == ST_CORRECT && mod_clk_en && residual != '0) begin
                residual <= residual - TS_W'(step_now);
            end else if (st == ST_SETTLE && drdy && settle_cnt != '0) begin
                settle_cnt <= settle_cnt - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        data_invalid = (st == ST_CORRECT) || (st == ST_SETTLE);
        state_o      = st;
    end
endmodule

// File: rtl/sdp_checker.sv
module sdp_checker #(
    parameter int TS_W  = 32,
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_pulse,
    input logic             drdy,
    input logic             mod_clk_en,
    input logic             filt_rst,
    input logic             data_invalid,
    input logic             err_late,
    input logic [TS_W-1:0]  err_mag,
    input logic [2:0]       state_o,
    input logic [DIV_W-1:0] cfg_div_nom,
    input logic [DIV_W-1:0] cfg_max_step
);
    localparam int IW = DIV_W + 2;

    logic [IW-1:0] ivl, hi, lo;
    logic          win_ok, period_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivl    <= '0;
            win_ok <= 1'b0;
        end else begin
            if (mod_clk_en) begin
                ivl    <= IW'(1);
                win_ok <= (state_o == 3'd1) || (state_o == 3'd2);
            end else if (ivl != '1) begin
                ivl <= ivl + 1'b1;
            end
        end
    end

    always_comb begin
        hi = IW'(cfg_div_nom) + IW'(cfg_max_step);
        lo = (cfg_max_step >= cfg_div_nom) ? '0 : IW'(cfg_div_nom) - IW'(cfg_max_step);
        period_ok = (ivl <= hi) && (ivl >= lo);
    end

    assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4);

    assert_rst_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        filt_rst |=> !filt_rst);

    assert_rst_in_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        filt_rst |-> state_o == 3'd3);

    assert_period_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_clk_en && win_ok && state_o == 3'd2) |-> period_ok);

    assert_invalid_correct_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2) |-> data_invalid);

    assert_sync_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pulse && (state_o == 3'd2 || state_o == 3'd3))
            |=> (state_o == 3'd2 || state_o == 3'd3 || state_o == 3'd4));

    assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (drdy && state_o == 3'd4) |=> ($stable(err_mag) && $stable(err_late)));

    assert_settle_invalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3) |-> data_invalid);
endmodule

bind sd_phase_aligner sdp_checker #(.TS_W(TS_W), .DIV_W(DIV_W)) u_sdp_checker (
    .clk(clk), .rst_n(rst_n), .sync_pulse(sync_pulse), .drdy(drdy),
    .mod_clk_en(mod_clk_en), .filt_rst(filt_rst), .data_invalid(data_invalid),
    .err_late(err_late), .err_mag(err_mag), .state_o(state_o),
    .cfg_div_nom(cfg_div_nom), .cfg_max_step(cfg_max_step)
);

// File: tb/test_sd_phase_aligner.sv
module test_sd_phase_aligner;
    localparam int TS_W = 10;

    typedef struct packed {
        logic        rmode;
        logic [15:0] gd;
        logic [7:0]  nom;
        logic [15:0] delta;
        logic [9:0]  tol;
        logic [7:0]  step;
        logic [7:0]  settle;
        logic [9:0]  mag;
        logic        late;
        logic [2:0]  st_exp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 16'd10, 8'd4, 16'd60, 10'd2, 8'd3, 8'd0, 10'd20, 1'b1, 3'd2},
        '{1'b0, 16'd10, 8'd4, 16'd25, 10'd2, 8'd2, 8'd0, 10'd15, 1'b0, 3'd2},
        '{1'b1, 16'd5,  8'd6, 16'd40, 10'd4, 8'd1, 8'd3, 10'd10, 1'b1, 3'd3},
        '{1'b1, 16'd8,  8'd5, 16'd37, 10'd4, 8'd1, 8'd3, 10'd3,  1'b0, 3'd4},
        '{1'b0, 16'd0,  8'd8, 16'd7,  10'd0, 8'd1, 8'd0, 10'd7,  1'b1, 3'd2},
        '{1'b1, 16'd20, 8'd3, 16'd10, 10'd4, 8'd1, 8'd0, 10'd50, 1'b0, 3'd3},
        '{1'b0, 16'd2,  8'd5, 16'd16, 10'd6, 8'd2, 8'd0, 10'd6,  1'b1, 3'd4}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sync_pulse = 1'b0;
    logic            drdy = 1'b0;
    logic            cfg_reset_mode = 1'b0;
    logic [15:0]     cfg_group_delay = '0;
    logic [7:0]      cfg_div_nom = 8'd4;
    logic [7:0]      cfg_max_step = 8'd1;
    logic [TS_W-1:0] cfg_tol = '0;
    logic [7:0]      cfg_settle = '0;
    logic            mod_clk_en, filt_rst, data_invalid, err_late;
    logic [TS_W-1:0] err_mag;
    logic [2:0]      state_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sd_phase_aligner #(.TS_W(TS_W)) i_sd_phase_aligner (
        .clk(clk), .rst_n(rst_n), .sync_pulse(sync_pulse), .drdy(drdy),
        .cfg_reset_mode(cfg_reset_mode), .cfg_group_delay(cfg_group_delay),
        .cfg_div_nom(cfg_div_nom), .cfg_max_step(cfg_max_step),
        .cfg_tol(cfg_tol), .cfg_settle(cfg_settle),
        .mod_clk_en(mod_clk_en), .filt_rst(filt_rst),
        .data_invalid(data_invalid), .err_late(err_late),
        .err_mag(err_mag), .state_o(state_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic pulse_drdy();
        drdy = 1'b1;
        @(negedge clk);
        drdy = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int last, dsum, after, guard, dev, lim, expsum;
        cfg_reset_mode  = v.rmode;
        cfg_group_delay = v.gd;
        cfg_div_nom     = v.nom;
        cfg_tol         = v.tol;
        cfg_max_step    = v.step;
        cfg_settle      = v.settle;
        @(negedge clk);
        sync_pulse = 1'b1;
        @(negedge clk);
        sync_pulse = 1'b0;
        chk(state_o == 3'd1, "R3", "state after sync", state_o, 1);
        repeat (int'(v.delta) - 1) @(negedge clk);
        pulse_drdy();
        // R3 error value and flag, R4 tolerance decision
        chk(err_mag == v.mag, "R3", $sformatf("err_mag vec%0d", idx), err_mag, v.mag);
        chk(err_late == v.late, "R3", $sformatf("err_late vec%0d", idx), err_late, v.late);
        chk(state_o == v.st_exp, "R4", $sformatf("state after measure vec%0d", idx),
            state_o, v.st_exp);
        if (v.st_exp == 3'd4) begin
            chk(!filt_rst && !data_invalid, "R4", "no correction within tolerance",
                {filt_rst, data_invalid}, 0);
        end else if (v.st_exp == 3'd3) begin
            chk(filt_rst == 1'b1, "R5", "filter reset strobe", filt_rst, 1);
            chk(data_invalid == 1'b1, "R11", "invalid in settle", data_invalid, 1);
            @(negedge clk);
            chk(filt_rst == 1'b0, "R5", "strobe single cycle", filt_rst, 0);
            for (int k = 0; k < int'(v.settle); k++) begin
                if (k == 0) sync_pulse = 1'b1;   // R8: sync in SETTLE ignored
                @(negedge clk);
                sync_pulse = 1'b0;
                pulse_drdy();
                @(negedge clk);
                if (k < int'(v.settle) - 1)
                    chk(state_o == 3'd3 && data_invalid, "R11", "still settling",
                        state_o, 3);
            end
            @(negedge clk);
            @(negedge clk);
            chk(state_o == 3'd4 && !data_invalid, "R11", "locked after settle count",
                state_o, 4);
        end else begin
            last = -1; dsum = 0; after = 0; guard = 0;
            lim = int'(v.step);
            while (after < 2 && guard < 3000) begin
                if (mod_clk_en) begin
                    if (last >= 0) begin
                        dev = (cyc - last) - int'(v.nom);
                        if (dev > lim || dev < -lim || (v.late && dev > 0) ||
                            (!v.late && dev < 0))
                            chk(1'b0, "R6", "period deviation", dev, 0);
                        dsum += dev;
                    end
                    last = cyc;
                    if (state_o == 3'd4) after++;
                end
                if (state_o == 3'd2 && !data_invalid)
                    chk(1'b0, "R7", "invalid during correct", data_invalid, 1);
                sync_pulse = (idx == 0 && guard == 5);   // R8: sync in CORRECT
                @(negedge clk);
                guard++;
            end
            sync_pulse = 1'b0;
            expsum = v.late ? -int'(v.mag) : int'(v.mag);
            chk(dsum == expsum, "R7", $sformatf("total period bend vec%0d", idx),
                dsum, expsum);
            chk(state_o == 3'd4 && !data_invalid, "R8", "ends locked", state_o, 4);
            chk(err_mag == v.mag, "R8", "error kept through correction", err_mag, v.mag);
            chk(1'b1, "R6", "period bounds scanned", 0, 0);
        end
        // R10: drdy while locked leaves results alone
        pulse_drdy();
        @(negedge clk);
        chk(err_mag == v.mag && err_late == v.late && state_o == 3'd4, "R10",
            "drdy in LOCKED ignored", err_mag, v.mag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WATCHDOG", "timeout", 0, 1);
        summary();
    end

    initial begin
        int t0;
        vec_t w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(state_o == 3'd0, "R1", "reset state", state_o, 0);
        chk(!filt_rst && !data_invalid, "R1", "reset outputs",
            {filt_rst, data_invalid}, 0);
        // R10: drdy in IDLE ignored
        pulse_drdy();
        chk(state_o == 3'd0 && err_mag == '0, "R10", "drdy in IDLE ignored", err_mag, 0);
        // R2: nominal tick spacing
        while (!mod_clk_en) @(negedge clk);
        t0 = cyc;
        @(negedge clk);
        while (!mod_clk_en) @(negedge clk);
        chk(cyc - t0 == 4, "R2", "nominal period", cyc - t0, 4);
        t0 = cyc;
        @(negedge clk);
        while (!mod_clk_en) @(negedge clk);
        chk(cyc - t0 == 4, "R2", "nominal period again", cyc - t0, 4);

        foreach (VECS[i]) run_vec(VECS[i], i);

        // R9: measurement across the counter wrap
        while ((cyc % 1024) != 1000) @(negedge clk);
        w = '{1'b1, 16'd4, 8'd4, 16'd30, 10'd2, 8'd1, 8'd0, 10'd14, 1'b1, 3'd3};
        run_vec(w, 100);
        chk(err_mag == 10'd14, "R9", "wrap-straddling error", err_mag, 14);
        summary();
    end
endmodule